// File: doc/BRIEF.md
# IPv4 Forwarding Header Parser

This block sits in the receive path of a packet-processing element. It takes in the front of a packet as a stream of 32-bit words under a valid/ready handshake. With the first word it samples a sideband made of a 16-bit source identifier, a source-type flag and a 16-bit router identifier. Bytes are big-endian: the first byte of a word sits in bits [31:24]. A packet handed over by a peer processing element begins with an internal shim, which the block skips. A packet from an external line interface begins directly with its IPv4 header.

Once the last word is in, the block checks the header and decides whether to drop it. It lowers the TTL by one and patches the header checksum incrementally. It presents the only header word that changes (TTL, protocol, checksum), a 144-bit lookup key, 4 lookup flags, 12 exception bits and a drop indication. Packets with exception conditions are not dropped: they go on to the next stage flagged. Three counters record how each packet was classified. The block accepts one packet at a time. Its input stays stalled until the previous result has been taken.

Top module: `ipv4_hdr_parser`

## Requirements
- R1: The outputs become valid on the clock edge that accepts the word marked last, so `out_valid` is high one cycle after that word. While `out_valid` is high and `out_ready` is low, all outputs hold steady and `in_ready` is low. `out_valid` falls on the edge where `out_ready` is seen high.
- R2: `in_src_flags` bit 0 equal to 0 means a line packet: IPv4 starts at byte 0 and `out_rx_if` equals `in_src_id`. Bit 0 equal to 1 means a peer packet: it carries a shim of type byte (byte 0), length byte (byte 1) and receive interface ID (bytes 2-3), then 2 to 6 bytes of type data. IPv4 starts at byte offset equal to the length byte, and `out_rx_if` is taken from shim bytes 2-3.
- R3: A peer packet whose shim length byte is not 6, 8 or 10 is dropped.
- R4: A packet is dropped unless all of these hold: version is 4, IHL is at least 5, total length is at least IHL×4, every header byte was received, and the ones'-complement sum over the IHL×4 header bytes equals 0xFFFF.
- R5: `out_hdr_w2` holds header bytes 8-11 (TTL, protocol, checksum). When the packet is not dropped and its TTL is nonzero, the TTL is one less and the checksum is updated so that the header still verifies. Otherwise the word is passed through unchanged.
- R6: Exception bit 0 is set when the incoming TTL is 0 or 1. Bit 1 is set when IHL is greater than 5. Bits 11:2 are zero. Neither condition by itself causes a drop.
- R7: The key holds `in_rtr_id` in [143:128], the receive interface in [127:112], the destination address in [111:80], the source address in [79:48], the transport port word in [47:16], the protocol in [15:8] and the TCP flags in [7:0].
- R8: The port word is the first 32-bit word after the IPv4 header, options included. It is nonzero only for protocol 6 or 17, and only if it was received. The TCP-flags byte is transport byte 13; it is zero unless the protocol is 6 and that byte was received.
- R9: Lookup flags are 0 for line packets. For a peer packet, shim type 1 gives 4'b0001. Shim type 2 gives 4'b0011 and puts shim bytes 4-7 in key bits [111:80] in place of the destination. Shim type 2 with a length below 8 is dropped. Bit 1 is never set without bit 0.
- R10: For each packet exactly one counter advances: `cnt_drop` if dropped, otherwise `cnt_exc` if any exception bit is set, otherwise `cnt_pass`.
- R11: After reset `out_valid` is low, `in_ready` is high and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 32 | Packet word, first byte in [31:24] |
| in_last | input | 1 | Final word of the packet |
| in_src_flags | input | 4 | Source flags, bit 0 = peer element |
| in_src_id | input | 16 | Receive interface or peer ID |
| in_rtr_id | input | 16 | Router ID placed in the key |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken |
| out_key | output | 144 | Lookup key |
| out_lkp_flags | output | 4 | Lookup flags |
| out_exc | output | 12 | Exception bits |
| out_drop | output | 1 | Packet failed validation |
| out_rx_if | output | 16 | Receive interface ID |
| out_hdr_w2 | output | 32 | Rewritten header bytes 8-11 |
| cnt_pass | output | CNT_W | Packets passed clean |
| cnt_drop | output | CNT_W | Packets dropped |
| cnt_exc | output | CNT_W | Packets forwarded with exceptions |

## Verification
The hardest case to reach is a peer packet whose shim length is not a multiple of four. In that case the IPv4 header, its checksum span and the transport word all straddle input word boundaries at a halfword offset. The bench assembles packets byte by byte and sends shims of length 6, 8 and 10. It adds a header with options, so that the port word moves past the fixed header. It also sends an odd shim length and a type-2 shim that is too short for its next-hop field, so both reach the drop path.

// File: rtl/ipv4p_pkg.sv
`timescale 1ns/1ps
package ipv4p_pkg;
  localparam int KEY_W    = 144;
  localparam int EXC_W    = 12;
  localparam int LKF_W    = 4;
  localparam int MIN_IHL  = 5;
  localparam int MAX_IHL  = 15;
  localparam int HDR_HW   = MAX_IHL * 2;   // halfwords in the largest header
  localparam int VIEW_HW  = HDR_HW + 7;    // reach up to the TCP flags halfword
  localparam logic [7:0] PROTO_TCP = 8'd6;
  localparam logic [7:0] PROTO_UDP = 8'd17;
  localparam logic [7:0] SHIM_SUBST = 8'd1;
  localparam logic [7:0] SHIM_NHOP  = 8'd2;

  // ones'-complement 16-bit add with end-around carry
  function automatic logic [15:0] oc_add16(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  // fold a wide accumulator of halfwords into a 16-bit ones'-complement sum
  function automatic logic [15:0] oc_fold32(input logic [31:0] x);
    return oc_add16(x[15:0], x[31:16]);
  endfunction

  function automatic logic shim_len_ok(input logic [7:0] len);
    return (len == 8'd6) || (len == 8'd8) || (len == 8'd10);
  endfunction

  function automatic logic [LKF_W-1:0] shim_lkp_flags(input logic peer, input logic [7:0] typ);
    if (!peer)                return '0;
    else if (typ == SHIM_SUBST) return 4'b0001;
    else if (typ == SHIM_NHOP)  return 4'b0011;
    else                      return '0;
  endfunction

  // TTL minus one, checksum raised by 0x0100 to compensate
  function automatic logic [31:0] ttl_dec_word(input logic [31:0] w2);
    return {w2[31:24] - 8'd1, w2[23:16], oc_add16(w2[15:0], 16'h0100)};
  endfunction
endpackage

// File: rtl/ipv4p_collect.sv
`timescale 1ns/1ps
module ipv4p_collect #(
  parameter int MAX_WORDS = 24,
  localparam int IW = $clog2(MAX_WORDS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       accept,
  input  logic [31:0]                in_data,
  input  logic                       in_last,
  input  logic [3:0]                 in_src_flags,
  input  logic [15:0]                in_src_id,
  input  logic [15:0]                in_rtr_id,
  output logic [MAX_WORDS-1:0][31:0] view_words,
  output logic [IW-1:0]              view_cnt,
  output logic [3:0]                 view_flags,
  output logic [15:0]                view_src_id,
  output logic [15:0]                view_rtr_id,
  output logic                       done
);
  logic [MAX_WORDS-1:0][31:0] words_q;
  logic [IW-1:0]              cnt_q;
  logic [3:0]                 flags_q;
  logic [15:0]                src_q, rtr_q;
  logic                       first_w, room_w;

  assign first_w = (cnt_q == '0);
  assign room_w  = int'(cnt_q) < MAX_WORDS;
  assign done    = accept && in_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words_q <= '0;
      cnt_q   <= '0;
      flags_q <= '0;
      src_q   <= '0;
      rtr_q   <= '0;
    end else if (accept) begin
      for (int i = 0; i < MAX_WORDS; i++)
        if (room_w && int'(cnt_q) == i) words_q[i] <= in_data;
      if (first_w) begin
        flags_q <= in_src_flags;
        src_q   <= in_src_id;
        rtr_q   <= in_rtr_id;
      end
      if (in_last)     cnt_q <= '0;
      else if (room_w) cnt_q <= cnt_q + 1'b1;
    end
  end

  // the word accepted this cycle is visible to the inspector at once
  always_comb begin
    for (int i = 0; i < MAX_WORDS; i++)
      view_words[i] = (accept && room_w && int'(cnt_q) == i) ? in_data : words_q[i];
    view_cnt    = (accept && room_w) ? cnt_q + 1'b1 : cnt_q;
    view_flags  = (accept && first_w) ? in_src_flags : flags_q;
    view_src_id = (accept && first_w) ? in_src_id    : src_q;
    view_rtr_id = (accept && first_w) ? in_rtr_id    : rtr_q;
  end
endmodule

// File: rtl/ipv4p_inspect.sv
`timescale 1ns/1ps
module ipv4p_inspect import ipv4p_pkg::*; #(
  parameter int MAX_WORDS = 24,
  localparam int IW = $clog2(MAX_WORDS + 1),
  localparam int HWN = 2 * MAX_WORDS
) (
  input  logic [MAX_WORDS-1:0][31:0] words,
  input  logic [IW-1:0]              nwords,
  input  logic [3:0]                 src_flags,
  input  logic [15:0]                src_id,
  input  logic [15:0]                rtr_id,
  output logic [KEY_W-1:0]           key,
  output logic [LKF_W-1:0]           lkp_flags,
  output logic [EXC_W-1:0]           exc,
  output logic                       drop,
  output logic [15:0]                rx_if,
  output logic [31:0]                hdr_w2
);
  logic [15:0] hw [HWN];
  logic [15:0] ah [VIEW_HW];
  logic        peer, shim_ok, nh_need, nh_ok, full, csum_ok, ttl_dec;
  logic [7:0]  shim_type, shim_len, ttl, proto, tcp_flg;
  logic [15:0] shim_rx, tlen, csum_sum;
  logic [3:0]  ver, ihl;
  logic [2:0]  base_hw;
  logic [31:0] acc, dst, src, ports;
  int          start_b, hdr_b, hdr_hw, have_b;
  logic [2:0]  unused_flags;

  assign unused_flags = src_flags[3:1];

  always_comb begin
    for (int i = 0; i < MAX_WORDS; i++) begin
      hw[2*i]   = words[i][31:16];
      hw[2*i+1] = words[i][15:0];
    end
  end

  // shim decode: type, length, receive interface in word 0
  always_comb begin
    peer      = src_flags[0];
    shim_type = words[0][31:24];
    shim_len  = words[0][23:16];
    shim_rx   = words[0][15:0];
    shim_ok   = !peer || shim_len_ok(shim_len);
    nh_need   = peer && (shim_type == SHIM_NHOP);
    nh_ok     = !nh_need || (shim_len >= 8'd8);
    base_hw   = (peer && shim_ok) ? shim_len[3:1] : 3'd0;
  end

  // halfword realignment onto the IPv4 header start
  always_comb begin
    for (int k = 0; k < VIEW_HW; k++) begin
      int idx;
      idx   = int'(base_hw) + k;
      ah[k] = (idx < HWN) ? hw[idx] : 16'h0000;
    end
  end

  always_comb begin
    ver     = ah[0][15:12];
    ihl     = ah[0][11:8];
    tlen    = ah[1];
    ttl     = ah[4][15:8];
    proto   = ah[4][7:0];
    src     = {ah[6], ah[7]};
    dst     = nh_need ? words[1] : {ah[8], ah[9]};
    start_b = int'(base_hw) * 2;
    hdr_hw  = int'(ihl) * 2;
    hdr_b   = int'(ihl) * 4;
    have_b  = int'(nwords) * 4;
    full    = have_b >= start_b + hdr_b;

    acc = '0;
    for (int k = 0; k < HDR_HW; k++)
      if (k < hdr_hw) acc = acc + {16'h0000, ah[k]};
    csum_sum = oc_fold32(acc);
    csum_ok  = (csum_sum == 16'hFFFF);

    drop = !shim_ok || !nh_ok || (ver != 4'd4) || (int'(ihl) < MIN_IHL) ||
           (int'(tlen) < hdr_b) || !full || !csum_ok;

    ports = '0;
    if ((proto == PROTO_TCP || proto == PROTO_UDP) && have_b >= start_b + hdr_b + 4)
      ports = {ah[hdr_hw], ah[hdr_hw+1]};
    tcp_flg = '0;
    if (proto == PROTO_TCP && have_b >= start_b + hdr_b + 14)
      tcp_flg = ah[hdr_hw+6][7:0];

    rx_if     = peer ? shim_rx : src_id;
    lkp_flags = shim_lkp_flags(peer, shim_type);
    exc       = '0;
    exc[0]    = (ttl <= 8'd1);
    exc[1]    = (int'(ihl) > MIN_IHL);
    ttl_dec   = !drop && (ttl != 8'd0);
    hdr_w2    = ttl_dec ? ttl_dec_word({ah[4], ah[5]}) : {ah[4], ah[5]};
    key       = {rtr_id, rx_if, dst, src, ports, proto, tcp_flg};
  end

  always_comb begin
    AST_PORTS_GATED: assert ((key[15:8] == PROTO_TCP) || (key[15:8] == PROTO_UDP) || (key[47:16] == 32'd0)) else $error("port word set for non-transport protocol"); // R8
  end
endmodule

// File: rtl/ipv4p_tally.sv
`timescale 1ns/1ps
module ipv4p_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             drop,
  input  logic             exc_any,
  output logic [CNT_W-1:0] cnt_pass,
  output logic [CNT_W-1:0] cnt_drop,
  output logic [CNT_W-1:0] cnt_exc
);
  logic inc_pass, inc_drop, inc_exc;

  assign inc_drop = done && drop;
  assign inc_exc  = done && !drop && exc_any;
  assign inc_pass = done && !drop && !exc_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_pass <= '0;
      cnt_drop <= '0;
      cnt_exc  <= '0;
    end else begin
      if (inc_pass) cnt_pass <= cnt_pass + 1'b1;
      if (inc_drop) cnt_drop <= cnt_drop + 1'b1;
      if (inc_exc)  cnt_exc  <= cnt_exc + 1'b1;
    end
  end

  AST_ONE_COUNTER: assert property (@(posedge clk) disable iff (!rst_n) done |=> ($countones({cnt_pass != $past(cnt_pass), cnt_drop != $past(cnt_drop), cnt_exc != $past(cnt_exc)}) == 1)); // R10
endmodule

// File: rtl/ipv4_hdr_parser.sv
`timescale 1ns/1ps
module ipv4_hdr_parser import ipv4p_pkg::*; #(
  parameter int MAX_WORDS = 24,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  input  logic             in_last,
  input  logic [3:0]       in_src_flags,
  input  logic [15:0]      in_src_id,
  input  logic [15:0]      in_rtr_id,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [KEY_W-1:0] out_key,
  output logic [LKF_W-1:0] out_lkp_flags,
  output logic [EXC_W-1:0] out_exc,
  output logic             out_drop,
  output logic [15:0]      out_rx_if,
  output logic [31:0]      out_hdr_w2,
  output logic [CNT_W-1:0] cnt_pass,
  output logic [CNT_W-1:0] cnt_drop,
  output logic [CNT_W-1:0] cnt_exc
);
  localparam int IW = $clog2(MAX_WORDS + 1);

  logic                       accept, done;
  logic [MAX_WORDS-1:0][31:0] v_words;
  logic [IW-1:0]              v_cnt;
  logic [3:0]                 v_flags;
  logic [15:0]                v_src, v_rtr, i_rx_if;
  logic [KEY_W-1:0]           i_key;
  logic [LKF_W-1:0]           i_lkp;
  logic [EXC_W-1:0]           i_exc;
  logic                       i_drop;
  logic [31:0]                i_w2;

  assign in_ready = !out_valid;
  assign accept   = in_valid && in_ready;

  ipv4p_collect #(.MAX_WORDS(MAX_WORDS)) u_collect (
    .clk(clk), .rst_n(rst_n), .accept(accept), .in_data(in_data), .in_last(in_last),
    .in_src_flags(in_src_flags), .in_src_id(in_src_id), .in_rtr_id(in_rtr_id),
    .view_words(v_words), .view_cnt(v_cnt), .view_flags(v_flags),
    .view_src_id(v_src), .view_rtr_id(v_rtr), .done(done)
  );

  ipv4p_inspect #(.MAX_WORDS(MAX_WORDS)) u_inspect (
    .words(v_words), .nwords(v_cnt), .src_flags(v_flags), .src_id(v_src), .rtr_id(v_rtr),
    .key(i_key), .lkp_flags(i_lkp), .exc(i_exc), .drop(i_drop), .rx_if(i_rx_if), .hdr_w2(i_w2)
  );

  ipv4p_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .done(done), .drop(i_drop), .exc_any(|i_exc),
    .cnt_pass(cnt_pass), .cnt_drop(cnt_drop), .cnt_exc(cnt_exc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_key       <= '0;
      out_lkp_flags <= '0;
      out_exc       <= '0;
      out_drop      <= 1'b0;
      out_rx_if     <= '0;
      out_hdr_w2    <= '0;
    end else if (done) begin
      out_valid     <= 1'b1;
      out_key       <= i_key;
      out_lkp_flags <= i_lkp;
      out_exc       <= i_exc;
      out_drop      <= i_drop;
      out_rx_if     <= i_rx_if;
      out_hdr_w2    <= i_w2;
    end else if (out_valid && out_ready) begin
      out_valid     <= 1'b0;
    end
  end

  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready && in_last) |=> out_valid); // R1
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_key) && $stable(out_hdr_w2) && $stable(out_drop))); // R1
  AST_FLAG_ORDER: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> !(out_lkp_flags[1] && !out_lkp_flags[0])); // R9
  AST_EXC_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (out_exc[EXC_W-1:2] == '0)); // R6
endmodule

// File: tb/ipv4_hdr_parser_bench.sv
`timescale 1ns/1ps
module ipv4_hdr_parser_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [31:0]  in_data = '0;
  logic [3:0]   in_src_flags = '0;
  logic [15:0]  in_src_id = '0, in_rtr_id = 16'h00C3;
  logic         in_ready, out_valid, out_drop;
  logic [143:0] out_key;
  logic [3:0]   out_lkp_flags;
  logic [11:0]  out_exc;
  logic [15:0]  out_rx_if, cnt_pass, cnt_drop, cnt_exc;
  logic [31:0]  out_hdr_w2;

  ipv4_hdr_parser u_ipv4_hdr_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_src_flags(in_src_flags), .in_src_id(in_src_id), .in_rtr_id(in_rtr_id),
    .out_valid(out_valid), .out_ready(out_ready), .out_key(out_key), .out_lkp_flags(out_lkp_flags),
    .out_exc(out_exc), .out_drop(out_drop), .out_rx_if(out_rx_if), .out_hdr_w2(out_hdr_w2),
    .cnt_pass(cnt_pass), .cnt_drop(cnt_drop), .cnt_exc(cnt_exc)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cycles = 0;
  int ep = 0, ed = 0, ee = 0;
  logic [7:0] pb [0:159];
  int pbn, ipst, cur_ihl;
  logic [7:0] cur_ttl;
  logic [143:0] r_key;
  logic [31:0]  r_w2;
  localparam logic [31:0] SRC_A = 32'h0A000001, DST_A = 32'hC0A80105, PORTS = 32'h1F900035;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [143:0] act, input logic [143:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put8(input logic [7:0] b);
    pb[pbn] = b; pbn++;
  endtask

  function automatic logic [15:0] ocsum(input int st, input int nb);
    int acc = 0;
    for (int i = 0; i < nb; i += 2) acc += {pb[st+i], pb[st+i+1]};
    while (acc > 16'hFFFF) acc = (acc & 16'hFFFF) + (acc >> 16);
    return acc[15:0];
  endfunction

  task automatic clr();
    pbn = 0;
    for (int i = 0; i < 160; i++) pb[i] = 8'h00;
  endtask

  task automatic put_shim(input logic [7:0] typ, input logic [7:0] len, input logic [15:0] rx);
    put8(typ); put8(len); put8(rx[15:8]); put8(rx[7:0]);
    for (int i = 4; i < int'(len); i++)
      put8(i == 4 ? 8'h0A : i == 5 ? 8'h63 : i == 6 ? 8'h00 : i == 7 ? 8'h07 : 8'hEE);
  endtask

  task automatic add_ip(input logic [3:0] ver, input int ihl, input int tlen, input logic [7:0] ttl,
                        input logic [7:0] proto, input logic [7:0] tflg, input bit bad);
    int tl;
    logic [15:0] cs;
    ipst = pbn; cur_ihl = ihl; cur_ttl = ttl;
    tl = (tlen > 0) ? tlen : ihl * 4 + 16;
    put8({ver, 4'(ihl)}); put8(8'h00); put8(8'(tl >> 8)); put8(8'(tl));
    put8(8'h12); put8(8'h34); put8(8'h00); put8(8'h00);
    put8(ttl); put8(proto); put8(8'h00); put8(8'h00);
    for (int i = 3; i >= 0; i--) put8(SRC_A[i*8 +: 8]);
    for (int i = 3; i >= 0; i--) put8(DST_A[i*8 +: 8]);
    for (int i = 0; i < (ihl - 5) * 4; i++) put8(8'h01);
    cs = ~ocsum(ipst, ihl * 4);
    if (bad) cs = cs ^ 16'h0101;
    pb[ipst+10] = cs[15:8]; pb[ipst+11] = cs[7:0];
    for (int i = 3; i >= 0; i--) put8(PORTS[i*8 +: 8]);
    for (int i = 0; i < 8; i++) put8(8'h00);
    put8(8'h50); put8(tflg); put8(8'h20); put8(8'h00);
  endtask

  // send the packet, check R1 timing, and capture the result
  task automatic run_pkt(input logic [3:0] flg, input logic [15:0] sid, input int limit);
    int nw;
    nw = (pbn + 3) / 4;
    if (limit > 0 && limit < nw) nw = limit;
    for (int i = 0; i < nw; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_last = (i == nw - 1);
      in_data = {pb[4*i], pb[4*i+1], pb[4*i+2], pb[4*i+3]};
      in_src_flags = flg; in_src_id = sid;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk("R1", "valid one cycle after last", {out_valid, in_ready}, 2'b10);
    r_key = out_key; r_w2 = out_hdr_w2;
    @(negedge clk);
    chk("R1", "held while stalled", {out_valid, out_key, out_hdr_w2}, {1'b1, r_key, r_w2});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R1", "released after ready", out_valid, 1'b0);
  endtask

  function automatic logic [143:0] ekey(input logic [15:0] rx, input logic [31:0] dst,
                                       input logic [31:0] prt, input logic [7:0] pr, input logic [7:0] tf);
    return {16'h00C3, rx, dst, SRC_A, prt, pr, tf};
  endfunction

  task automatic chk_w2(input bit dropped);
    logic [31:0] orig;
    orig = {pb[ipst+8], pb[ipst+9], pb[ipst+10], pb[ipst+11]};
    if (dropped || cur_ttl == 8'd0) begin
      chk("R5", "header word unchanged", r_w2, orig);
    end else begin
      chk("R5", "ttl decremented", r_w2[31:16], {cur_ttl - 8'd1, orig[23:16]});
      {pb[ipst+8], pb[ipst+9], pb[ipst+10], pb[ipst+11]} = r_w2;
      chk("R5", "rewritten header verifies", ocsum(ipst, cur_ihl * 4), 16'hFFFF);
    end
  endtask

  task automatic t_reset();
    chk("R11", "reset valid/ready", {out_valid, in_ready}, 2'b01);
    chk("R11", "reset counters", {cnt_pass, cnt_drop, cnt_exc}, 48'd0);
  endtask

  task automatic t_line_udp();
    clr(); add_ip(4'd4, 5, 0, 8'd64, 8'd17, 8'hFF, 0);
    run_pkt(4'b0000, 16'h0111, 0);
    chk("R7", "line udp key", r_key, ekey(16'h0111, DST_A, PORTS, 8'd17, 8'h00));
    chk("R2", "line rx interface", out_rx_if, 16'h0111);
    chk("R9", "line lookup flags", out_lkp_flags, 4'b0000);
    chk("R4", "good header kept", {out_drop, out_exc}, 13'd0);
    chk_w2(0); ep++;
  endtask

  task automatic t_peer_tcp();
    clr(); put_shim(8'd0, 8'd6, 16'h0222); add_ip(4'd4, 5, 0, 8'd30, 8'd6, 8'h12, 0);
    run_pkt(4'b0001, 16'h0999, 0);
    chk("R2", "shim rx interface", out_rx_if, 16'h0222);
    chk("R8", "tcp ports and flags", r_key, ekey(16'h0222, DST_A, PORTS, 8'd6, 8'h12));
    chk("R9", "type 0 flags", {out_drop, out_lkp_flags}, 5'd0);
    chk_w2(0); ep++;
  endtask

  task automatic t_peer_subst();
    clr(); put_shim(8'd1, 8'd8, 16'h0333); add_ip(4'd4, 5, 0, 8'd9, 8'd1, 8'h00, 0);
    run_pkt(4'b0001, 16'h0999, 0);
    chk("R9", "substrate flag", {out_drop, out_lkp_flags}, 5'b00001);
    chk("R8", "icmp no ports", r_key, ekey(16'h0333, DST_A, 32'd0, 8'd1, 8'h00));
    ep++;
  endtask

  task automatic t_peer_nhop();
    clr(); put_shim(8'd2, 8'd10, 16'h0444); add_ip(4'd4, 5, 0, 8'd9, 8'd17, 8'h00, 0);
    run_pkt(4'b0001, 16'h0999, 0);
    chk("R9", "next-hop flags", {out_drop, out_lkp_flags}, 5'b00011);
    chk("R9", "next-hop in key word 1", r_key, ekey(16'h0444, 32'h0A630007, PORTS, 8'd17, 8'h00));
    chk_w2(0); ep++;
  endtask

  task automatic t_nhop_short();
    clr(); put_shim(8'd2, 8'd6, 16'h0555); add_ip(4'd4, 5, 0, 8'd9, 8'd17, 8'h00, 0);
    run_pkt(4'b0001, 16'h0999, 0);
    chk("R9", "type 2 short shim dropped", out_drop, 1'b1);
    chk_w2(1); ed++;
  endtask

  task automatic t_odd_shim();
    clr(); put_shim(8'd0, 8'd7, 16'h0666); add_ip(4'd4, 5, 0, 8'd9, 8'd17, 8'h00, 0);
    run_pkt(4'b0001, 16'h0999, 0);
    chk("R3", "odd shim length dropped", out_drop, 1'b1); ed++;
  endtask

  task automatic t_bad_fields();
    clr(); add_ip(4'd4, 5, 0, 8'd64, 8'd17, 8'h00, 1);
    run_pkt(4'b0000, 16'h0111, 0);
    chk("R4", "bad checksum dropped", out_drop, 1'b1);
    chk_w2(1); ed++;
    clr(); add_ip(4'd6, 5, 0, 8'd64, 8'd17, 8'h00, 0);
    run_pkt(4'b0000, 16'h0111, 0);
    chk("R4", "version 6 dropped", out_drop, 1'b1); ed++;
    clr(); add_ip(4'd4, 5, 16, 8'd64, 8'd17, 8'h00, 0);
    run_pkt(4'b0000, 16'h0111, 0);
    chk("R4", "total length below header dropped", out_drop, 1'b1); ed++;
    clr(); add_ip(4'd4, 5, 0, 8'd64, 8'd17, 8'h00, 0);
    run_pkt(4'b0000, 16'h0111, 4);
    chk("R4", "truncated header dropped", out_drop, 1'b1); ed++;
  endtask

  task automatic t_ttl_low();
    clr(); add_ip(4'd4, 5, 0, 8'd1, 8'd17, 8'h00, 0);
    run_pkt(4'b0000, 16'h0111, 0);
    chk("R6", "ttl 1 exception, kept", {out_drop, out_exc}, 13'h001);
    chk_w2(0); ee++;
    clr(); add_ip(4'd4, 5, 0, 8'd0, 8'd17, 8'h00, 0);
    run_pkt(4'b0000, 16'h0111, 0);
    chk("R6", "ttl 0 exception, kept", {out_drop, out_exc}, 13'h001);
    chk_w2(0); ee++;
  endtask

  task automatic t_options();
    clr(); put_shim(8'd0, 8'd6, 16'h0777); add_ip(4'd4, 6, 0, 8'd64, 8'd6, 8'h02, 0);
    run_pkt(4'b0001, 16'h0999, 0);
    chk("R6", "options exception", {out_drop, out_exc}, 13'h002);
    chk("R8", "ports after options", r_key, ekey(16'h0777, DST_A, PORTS, 8'd6, 8'h02));
    chk_w2(0); ee++;
  endtask

  task automatic t_counts();
    @(negedge clk);
    chk("R10", "pass count", cnt_pass, 16'(ep));
    chk("R10", "drop count", cnt_drop, 16'(ed));
    chk("R10", "exception count", cnt_exc, 16'(ee));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_line_udp();
    t_peer_tcp();
    t_peer_subst();
    t_peer_nhop();
    t_nhop_short();
    t_odd_shim();
    t_bad_fields();
    t_ttl_low();
    t_options();
    t_counts();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule